// File: doc/BRIEF.md
# Dual-Chain Serial Converter Loader

This block feeds sixteen serial digital-to-analogue converters that are wired as two daisy chains of eight. Each converter expects a 32-bit frame: a 16-bit command word followed by a 16-bit data word. The loader takes the sixteen command and sixteen data words as flat parallel buses from the surrounding register file. It copies them into two 256-bit shift registers at the start of a pass, one per chain, and clocks both chains at the same time on one shared serial clock. When the last bit is in place it raises a common load strobe, so that every converter output changes together.

An arm request starts the loading. In register mode a single pass runs and the armed flag clears by itself once the strobe has been issued. In memory mode the armed flag stays set, and passes follow one another until software clears it. A refresh request made during a register-mode pass keeps the flag set for one more pass, so that register values rewritten mid-pass reach the converters. A pass never mixes old and new values, because the register contents are copied at its start.

Top module: `dac_chain_loader`

## Requirements
- R1: Out of reset the serial clock is low, the frame select (active low) is high, and the load strobe, done pulse and armed flag are all low.
- R2: Each converter receives a 32-bit frame, most significant bit first. The command word occupies frame bits 31:16 and the data word bits 15:0. The command word is passed on unchanged, including a range code in bits 7:4 (8 to 12) with bits 3:0 zero.
- R3: Channels 0 to 7 go out on sdo_o[0] and channels 8 to 15 on sdo_o[1], both chains shifting on the same clock edges. Within a bank, the frame of the converter at position 7 (farthest) is sent first and that of position 0 last. After a pass, the converter at position p of bank b therefore holds channel 8·b+p.
- R4: A pass gives exactly 256 rising serial-clock edges with the frame select low throughout. The serial data changes only while the serial clock is low and stays stable while it is high. The serial clock is low whenever the frame select is high.
- R5: The load strobe is high for exactly one clock cycle, only after the last bit and with the frame select high. The done pulse follows one cycle later.
- R6: The load strobe is high in the cycle that begins 512·SCLK_HALF+1 clock cycles after the edge that samples arm_set_i from idle.
- R7: In register mode (mem_mode_i low) the armed flag clears once the load strobe has been issued, and no further pass starts.
- R8: In memory mode the armed flag stays set and passes repeat with load strobes 512·SCLK_HALF+2 cycles apart. After arm_clr_i, the pass under way completes and no new pass starts.
- R9: Register contents are sampled when a pass starts. Changes made during a pass appear only in the next pass.
- R10: A refresh_req_i pulse while armed in register mode keeps the armed flag set after the current pass, and one more pass follows that carries the new register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_regs_i | input | 256 | Command words, channel c at bits 16c+15:16c |
| data_regs_i | input | 256 | Data words, channel c at bits 16c+15:16c |
| arm_set_i | input | 1 | One-cycle request to arm |
| arm_clr_i | input | 1 | One-cycle request to disarm |
| mem_mode_i | input | 1 | 1 = memory mode (armed flag persists), 0 = register mode |
| refresh_req_i | input | 1 | Requests one more pass after the current one in register mode |
| sclk_o | output | 1 | Shared serial clock |
| sdo_o | output | 2 | Serial data, bit 0 chain A, bit 1 chain B |
| frame_n_o | output | 1 | Frame select, low during shifting |
| load_o | output | 1 | Common load strobe |
| done_o | output | 1 | One-cycle pulse after the strobe |
| armed_o | output | 1 | Armed flag |

## Verification
Frames are checked using a model of the converter chains that takes the serial bits on rising clock edges and decodes each position's frame at the strobe. The data patterns are random words with random legal range codes, and a directed set with all-zero and all-one words at the chain ends. These tell a reversed chain order, a swapped command/data half or a swapped bank apart from correct loading. Registers rewritten partway through a pass separate snapshot loading from live sampling. Register-mode, refresh and memory-mode runs separate the arming rules, and counted strobe latencies and spacings expose off-by-one timing.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } dcl_state_e;
endpackage

// File: rtl/dcl_reset_sync.sv
module dcl_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dcl_frame_pack.sv
// Orders one bank's words into the chain image: position p occupies
// bits p*FRAME_W +: FRAME_W, command in the upper half.
module dcl_frame_pack #(
  parameter int WORD_W      = 16,
  parameter int CH_PER_BANK = 8,
  localparam int FRAME_W    = 2 * WORD_W,
  localparam int BANK_W     = CH_PER_BANK * WORD_W,
  localparam int CHAIN_BITS = CH_PER_BANK * FRAME_W
) (
  input  logic [BANK_W-1:0]     cmd_i,
  input  logic [BANK_W-1:0]     data_i,
  output logic [CHAIN_BITS-1:0] chain_o
);
  for (genvar p = 0; p < CH_PER_BANK; p++) begin : g_pos
    assign chain_o[p*FRAME_W +: FRAME_W] =
      {cmd_i[p*WORD_W +: WORD_W], data_i[p*WORD_W +: WORD_W]};
  end
endmodule

// File: rtl/dcl_bank_shifter.sv
module dcl_bank_shifter #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic             shift_en_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             sdo_o
);
  logic [WIDTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_en_i)       sr_d = par_i;
    else if (shift_en_i) sr_d = {sr_q[WIDTH-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sdo_o = sr_q[WIDTH-1];
endmodule

// File: rtl/dcl_ctrl.sv
module dcl_ctrl
  import dcl_pkg::*;
#(
  parameter int SCLK_HALF  = 2,
  parameter int CHAIN_BITS = 256,
  localparam int CNT_W     = $clog2(CHAIN_BITS),
  localparam int PH_W      = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set_i,
  input  logic arm_clr_i,
  input  logic mem_mode_i,
  input  logic refresh_req_i,
  output logic load_en_o,
  output logic shift_en_o,
  output logic sclk_o,
  output logic frame_n_o,
  output logic load_o,
  output logic done_o,
  output logic armed_o
);
  dcl_state_e       state_q, state_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             sclk_q, sclk_d;
  logic             armed_q, armed_d;
  logic             pend_q, pend_d;
  logic             done_q, done_d;
  logic             ph_wrap;

  assign ph_wrap = (ph_q == PH_W'(SCLK_HALF - 1));

  always_comb begin
    state_d    = state_q;
    ph_d       = ph_q;
    bit_d      = bit_q;
    sclk_d     = sclk_q;
    armed_d    = armed_q;
    pend_d     = pend_q;
    load_en_o  = 1'b0;
    shift_en_o = 1'b0;
    done_d     = (state_q == ST_LOAD);

    unique case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (armed_q) begin
          state_d   = ST_SHIFT;
          load_en_o = 1'b1;
          ph_d      = '0;
          bit_d     = '0;
          sclk_d    = 1'b0;
        end
      end
      ST_SHIFT: begin
        pend_d = pend_q | (refresh_req_i & armed_q);
        if (ph_wrap) begin
          ph_d   = '0;
          sclk_d = ~sclk_q;
          if (sclk_q) begin
            shift_en_o = 1'b1;
            bit_d      = bit_q + 1'b1;
            if (bit_q == CNT_W'(CHAIN_BITS - 1)) state_d = ST_LOAD;
          end
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_LOAD: begin
        state_d = ST_IDLE;
        armed_d = armed_q & (mem_mode_i | pend_q | refresh_req_i);
      end
      default: state_d = ST_IDLE;
    endcase

    if (arm_clr_i) armed_d = 1'b0;
    if (arm_set_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      armed_q <= armed_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  assign sclk_o    = sclk_q;
  assign frame_n_o = (state_q != ST_SHIFT);
  assign load_o    = (state_q == ST_LOAD);
  assign done_o    = done_q;
  assign armed_o   = armed_q;
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader #(
  parameter int NUM_CH    = 16,
  parameter int NUM_BANKS = 2,
  parameter int WORD_W    = 16,
  parameter int SCLK_HALF = 2,
  localparam int CH_PER_BANK = NUM_CH / NUM_BANKS,
  localparam int BANK_W      = CH_PER_BANK * WORD_W,
  localparam int CHAIN_BITS  = CH_PER_BANK * 2 * WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*WORD_W-1:0] cmd_regs_i,
  input  logic [NUM_CH*WORD_W-1:0] data_regs_i,
  input  logic                     arm_set_i,
  input  logic                     arm_clr_i,
  input  logic                     mem_mode_i,
  input  logic                     refresh_req_i,
  output logic                     sclk_o,
  output logic [NUM_BANKS-1:0]     sdo_o,
  output logic                     frame_n_o,
  output logic                     load_o,
  output logic                     done_o,
  output logic                     armed_o
);
  logic rst_int_n;
  logic load_en, shift_en;

  dcl_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dcl_ctrl #(
    .SCLK_HALF  (SCLK_HALF),
    .CHAIN_BITS (CHAIN_BITS)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .arm_set_i     (arm_set_i),
    .arm_clr_i     (arm_clr_i),
    .mem_mode_i    (mem_mode_i),
    .refresh_req_i (refresh_req_i),
    .load_en_o     (load_en),
    .shift_en_o    (shift_en),
    .sclk_o        (sclk_o),
    .frame_n_o     (frame_n_o),
    .load_o        (load_o),
    .done_o        (done_o),
    .armed_o       (armed_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CHAIN_BITS-1:0] image;

    dcl_frame_pack #(
      .WORD_W      (WORD_W),
      .CH_PER_BANK (CH_PER_BANK)
    ) u_pack (
      .cmd_i   (cmd_regs_i[b*BANK_W +: BANK_W]),
      .data_i  (data_regs_i[b*BANK_W +: BANK_W]),
      .chain_o (image)
    );

    dcl_bank_shifter #(
      .WIDTH (CHAIN_BITS)
    ) u_shift (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .load_en_i  (load_en),
      .shift_en_i (shift_en),
      .par_i      (image),
      .sdo_o      (sdo_o[b])
    );
  end
endmodule

// File: rtl/dac_chain_loader_checker.sv
module dac_chain_loader_checker #(
  parameter int NUM_BANKS  = 2,
  parameter int CHAIN_BITS = 256,
  localparam int CW        = $clog2(CHAIN_BITS) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sclk_o,
  input logic [NUM_BANKS-1:0] sdo_o,
  input logic                 frame_n_o,
  input logic                 load_o,
  input logic                 done_o,
  input logic                 armed_o,
  input logic                 mem_mode_i,
  input logic                 arm_clr_i
);
  logic          sclk_prev;
  logic [CW-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      rise_cnt  <= '0;
    end else begin
      sclk_prev <= sclk_o;
      if (done_o)                    rise_cnt <= '0;
      else if (sclk_o && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_clk_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_o |-> !sclk_o);
  p_sdo_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdo_o));
  p_rise_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (rise_cnt == CW'(CHAIN_BITS)));
  p_load_unframed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> frame_n_o);
  p_load_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  p_done_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(load_o));
  p_mem_keeps_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && armed_o && mem_mode_i && !arm_clr_i) |=> armed_o);
endmodule

bind dac_chain_loader dac_chain_loader_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .CHAIN_BITS (CHAIN_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_o     (sclk_o),
  .sdo_o      (sdo_o),
  .frame_n_o  (frame_n_o),
  .load_o     (load_o),
  .done_o     (done_o),
  .armed_o    (armed_o),
  .mem_mode_i (mem_mode_i),
  .arm_clr_i  (arm_clr_i)
);

// File: tb/dac_chain_loader_bench.sv
module dac_chain_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 2;
  localparam int NCH        = 16;
  localparam int CHAIN      = 256;
  localparam int LAT        = 2 * H * CHAIN + 2;
  localparam int SPACING    = 2 * H * CHAIN + 2;

  typedef logic [15:0] w16_arr_t [NCH];

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH*16-1:0] cmd_flat, data_flat;
  logic           arm_set, arm_clr, mem_mode, refresh_req;
  logic           sclk, frame_n, load, done, armed;
  logic [1:0]     sdo;

  w16_arr_t cur_cmd, cur_dat, cap_cmd, cap_dat, old_cmd, old_dat;
  logic [CHAIN-1:0] sr_a = '0, sr_b = '0;
  int bits_seen = 0, last_bits = 0, load_count = 0;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cmd_flat[c*16 +: 16]  = cur_cmd[c];
      data_flat[c*16 +: 16] = cur_dat[c];
    end
  end

  dac_chain_loader #(.SCLK_HALF(H)) u_dac_chain_loader (
    .clk (clk), .rst_n (rst_n), .cmd_regs_i (cmd_flat), .data_regs_i (data_flat),
    .arm_set_i (arm_set), .arm_clr_i (arm_clr), .mem_mode_i (mem_mode),
    .refresh_req_i (refresh_req), .sclk_o (sclk), .sdo_o (sdo),
    .frame_n_o (frame_n), .load_o (load), .done_o (done), .armed_o (armed)
  );

  // Converter chain model: bits enter on rising serial clock.
  always @(posedge sclk) begin
    if (!frame_n) begin
      sr_a = {sr_a[CHAIN-2:0], sdo[0]};
      sr_b = {sr_b[CHAIN-2:0], sdo[1]};
      bits_seen = bits_seen + 1;
    end
  end

  always @(posedge load) begin
    for (int p = 0; p < 8; p++) begin
      cap_cmd[p]     = sr_a[p*32+16 +: 16];
      cap_dat[p]     = sr_a[p*32 +: 16];
      cap_cmd[p + 8] = sr_b[p*32+16 +: 16];
      cap_dat[p + 8] = sr_b[p*32 +: 16];
    end
    last_bits  = bits_seen;
    bits_seen  = 0;
    load_count = load_count + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int c = 0; c < NCH; c++) begin
      cur_cmd[c] = {8'h00, 4'(8 + ($urandom % 5)), 4'h0};
      cur_dat[c] = 16'($urandom);
    end
  endtask

  task automatic check_frames(input string req, input w16_arr_t ec, input w16_arr_t ed);
    for (int c = 0; c < NCH; c++) begin
      check(cap_cmd[c] == ec[c], {req, " cmd"}, cap_cmd[c], ec[c]);
      check(cap_dat[c] == ed[c], {req, " data"}, cap_dat[c], ed[c]);
    end
    check(last_bits == CHAIN, {req, " bit count R4"}, last_bits, CHAIN);
  endtask

  task automatic wait_load(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk); cnt++;
      @(negedge clk);
      arm_set = 1'b0; arm_clr = 1'b0; refresh_req = 1'b0;
    end while (!load && cnt < 3 * LAT);
  endtask

  task automatic arm_and_wait(output int cnt);
    arm_set = 1'b1;
    wait_load(cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt, lc;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; arm_set = 0; arm_clr = 0; mem_mode = 0; refresh_req = 0;
    for (int c = 0; c < NCH; c++) begin cur_cmd[c] = '0; cur_dat[c] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(!sclk && frame_n && !load && !done && !armed, "R1 reset outputs",
          {sclk, frame_n, load, done, armed}, 5'b01000);

    // Directed pass: extremes at chain ends, all range codes (R2, R3, R6, R7)
    for (int c = 0; c < NCH; c++) begin
      cur_cmd[c] = {8'h00, 4'(8 + c % 5), 4'h0};
      cur_dat[c] = 16'h1000 * 16'(c) + 16'h0A5;
    end
    cur_dat[0] = 16'h0000; cur_dat[7] = 16'hFFFF; cur_dat[8] = 16'hFFFF; cur_dat[15] = 16'h0000;
    arm_and_wait(cnt);
    check(cnt == LAT, "R6 arm to load latency", cnt, LAT);
    check_frames("R2 R3 directed", cur_cmd, cur_dat);
    @(negedge clk);
    check(done && !load, "R5 done follows load", {done, load}, 2'b10);
    check(!armed, "R7 armed self-clears", armed, 0);
    lc = load_count;
    repeat (2 * SPACING) @(negedge clk);
    check(load_count == lc && frame_n, "R7 no further pass", load_count, lc);

    // Random register-mode passes
    for (int i = 0; i < 4; i++) begin
      fill_random();
      arm_and_wait(cnt);
      check(cnt == LAT, "R6 latency random", cnt, LAT);
      check_frames("R2 R3 random", cur_cmd, cur_dat);
      @(negedge clk);
      check(!armed, "R7 armed clears random", armed, 0);
    end

    // R9 snapshot: rewrite mid-pass
    fill_random(); old_cmd = cur_cmd; old_dat = cur_dat;
    arm_set = 1'b1;
    @(negedge clk) arm_set = 1'b0;
    repeat (300) @(negedge clk);
    fill_random();
    wait_load(cnt);
    check_frames("R9 snapshot old values", old_cmd, old_dat);
    @(negedge clk);
    check(!armed, "R9 no repeat without request", armed, 0);
    arm_and_wait(cnt);
    check_frames("R9 next pass new values", cur_cmd, cur_dat);
    repeat (3) @(negedge clk);

    // R10 refresh request during a register pass
    fill_random(); old_cmd = cur_cmd; old_dat = cur_dat;
    arm_set = 1'b1;
    @(negedge clk) arm_set = 1'b0;
    repeat (300) @(negedge clk);
    fill_random();
    refresh_req = 1'b1;
    wait_load(cnt);
    check_frames("R10 first pass old", old_cmd, old_dat);
    @(negedge clk);
    check(armed, "R10 armed kept", armed, 1);
    wait_load(cnt);
    check(cnt == SPACING - 1, "R10 second pass spacing", cnt, SPACING - 1);
    check_frames("R10 second pass new", cur_cmd, cur_dat);
    @(negedge clk);
    check(!armed, "R10 armed clears after extra pass", armed, 0);

    // R8 memory mode
    mem_mode = 1'b1;
    fill_random();
    arm_and_wait(cnt);
    check_frames("R8 memory first", cur_cmd, cur_dat);
    fill_random();
    wait_load(cnt);
    check(cnt == SPACING, "R8 load spacing", cnt, SPACING);
    check_frames("R8 memory second", cur_cmd, cur_dat);
    @(negedge clk);
    check(armed, "R8 armed persists", armed, 1);
    repeat (300) @(negedge clk);
    arm_clr = 1'b1;
    wait_load(cnt);
    check(cnt == SPACING - 301, "R8 current pass completes", cnt, SPACING - 301);
    check_frames("R8 final pass", cur_cmd, cur_dat);
    @(negedge clk);
    check(!armed, "R8 disarmed", armed, 0);
    lc = load_count;
    repeat (2 * SPACING) @(negedge clk);
    check(load_count == lc && frame_n && !sclk, "R8 stops after clear", load_count, lc);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule